// File: doc/BRIEF.md
# Power-Gated Two-Register I2C Target

This block is an I2C target that gives a host processor control over two small system registers. It samples the serial clock and data lines on a faster system clock, finds START and STOP conditions, and answers a 7-bit address. Five upper address bits are fixed and the two lowest bits come from strap pins. The target drives the data line only by pulling it low, through an enable output that an external open-drain pad turns into a bus level.

On a write, the host may send any number of data bytes. The top bit of each byte picks the target register, and the writable bits of that register take the byte's value. On a read, the target sends the first register and then the second, and keeps alternating for as long as the host acknowledges. Two fault flags from outside appear in fixed read-only positions. While the power-good input is low, the target acknowledges nothing and stores nothing.

Top module: `lnb_sysreg_i2c`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal {5'b00010, addr_pin_i}. Bit 0 of that byte is the direction, with 1 meaning read and 0 meaning write.
- R2: An address byte with any other value gets no acknowledge, and the data bytes that follow it in the same transfer are neither acknowledged nor stored.
- R3: Bytes are shifted most significant bit first. The target pulls SDA low only in the ninth clock of a byte it acknowledges, never during the eight data bits of a byte it receives.
- R4: In a written data byte, bit 7 = 0 stores bits 6..1 into register A, and bit 7 = 1 stores bit 2 into register B. All other bits of the byte are ignored.
- R5: Register A reads back as {0, stored bits 6..1, ovl_flag_i}. Register B reads back as {5'b0, stored bit 2, ot_flag_i, 0}. Writes cannot change the flag positions.
- R6: Several data bytes may follow one write address before the STOP, and each one is acknowledged and applied in order.
- R7: While pwr_ok_i is low, the target acknowledges neither address nor data bytes and stores no data.
- R8: After reset, every stored bit is 0 and sda_pull_o is 0.
- R9: A read sends register A first and then register B, alternating while the host acknowledges. After a byte the host does not acknowledge, the target leaves SDA released.
- R10: A STOP returns the target to idle, so later bytes are ignored until a START. A repeated START restarts address reception.
- R11: sda_pull_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| addr_pin_i | input | 2 | Strap pins giving the low two address bits |
| pwr_ok_i | input | 1 | Power good; acknowledges are withheld while low |
| ovl_flag_i | input | 1 | Overload fault flag, read-only in register A |
| ot_flag_i | input | 1 | Over-temperature flag, read-only in register B |

## Verification
A table of single-byte writes cycles the register-select bit, all-ones and all-zeros data, an asymmetric pattern and two address mismatches. The mismatches sit one in the strap bits and one in the fixed bits, so decode is checked on both parts of the address. Each write is followed by a readback of both registers. The asymmetric byte separates MSB-first shifting from reversed order, and writes of all ones and all zeros show which bit positions are masked. Directed transfers then cover multi-byte writes, read order and release after a host NACK, power-good gating on the address and on the data byte, repeated START, STOP abort and the fault flags.

// File: rtl/lnb_i2c_pkg.sv
package lnb_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  // positions decoded by the register bank
  localparam int SEL_BIT  = 7;
  localparam int A_HI     = 6;
  localparam int A_LO     = 1;
  localparam int A_W      = A_HI - A_LO + 1;
  localparam int B_EN_BIT = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_DACK,
    ST_TX,
    ST_MACK
  } i2c_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] line_s;
  logic [LINES-1:0] prev_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-2:0], raw[g]};
    end
    assign line_s[g] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= line_s;
  end

  assign scl_s     = line_s[1];
  assign sda_s     = line_s[0];
  assign scl_rise  = scl_s & ~prev_q[1];
  assign scl_fall  = ~scl_s & prev_q[1];
  assign start_det = scl_s & prev_q[1] & prev_q[0] & ~sda_s;
  assign stop_det  = scl_s & prev_q[1] & ~prev_q[0] & sda_s;
endmodule

// File: rtl/lnb_reg_bank.sv
module lnb_reg_bank
  import lnb_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ovl_flag,
  input  logic              ot_flag,
  output logic [BYTE_W-1:0] rd_a,
  output logic [BYTE_W-1:0] rd_b
);
  logic [A_W-1:0] a_q, a_d;
  logic           b_q, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (wr_en) begin
      if (wr_data[SEL_BIT]) b_d = wr_data[B_EN_BIT];
      else                  a_d = wr_data[A_HI:A_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign rd_a = {1'b0, a_q, ovl_flag};
  assign rd_b = {5'b0, b_q, ot_flag, 1'b0};

  // R4
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import lnb_i2c_pkg::*;
#(
  parameter int               PIN_W     = 2,
  parameter logic [6-PIN_W:0] ADDR_BASE = 5'b00010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [PIN_W-1:0]  addr_pin,
  input  logic              pwr_ok,
  input  logic [BYTE_W-1:0] rd_a,
  input  logic [BYTE_W-1:0] rd_b,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  i2c_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              pull_q, pull_d;
  logic              rw_q, rw_d;
  logic              sel_q, sel_d;
  logic              nack_q, nack_d;
  logic [BYTE_W-1:0] next_rd;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {ADDR_BASE, addr_pin});
  assign next_rd  = sel_q ? rd_b : rd_a;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    pull_d  = pull_q;
    rw_d    = rw_q;
    sel_d   = sel_q;
    nack_d  = nack_q;
    wr_en   = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (!pwr_ok) begin
              state_d = ST_IDLE;
            end else if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                pull_d  = 1'b1;
                rw_d    = sh_q[0];
                state_d = ST_AACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              pull_d  = 1'b1;
              wr_en   = 1'b1;
              state_d = ST_DACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              sh_d    = rd_a;
              pull_d  = ~rd_a[BYTE_W-1];
              sel_d   = 1'b1;
              state_d = ST_TX;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_RX;
            end
          end
        end
        ST_DACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            cnt_d   = '0;
            state_d = ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              pull_d  = 1'b0;
              state_d = ST_MACK;
            end else begin
              sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
              pull_d = ~sh_q[BYTE_W-2];
              cnt_d  = cnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (!nack_q) begin
              sh_d    = next_rd;
              pull_d  = ~next_rd[BYTE_W-1];
              sel_d   = ~sel_q;
              cnt_d   = '0;
              state_d = ST_TX;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      pull_q  <= 1'b0;
      rw_q    <= 1'b0;
      sel_q   <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      pull_q  <= pull_d;
      rw_q    <= rw_d;
      sel_q   <= sel_d;
      nack_q  <= nack_d;
    end
  end

  assign sda_pull = pull_q;
  assign wr_data  = sh_q;

  // R7
  ack_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pull_q) && (state_q == ST_AACK || state_q == ST_DACK)) |-> $past(pwr_ok));

  // R11
  pull_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !scl_s);

  // R10
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !pull_q));

  // R10
  start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state_q == ST_ADDR && cnt_q == '0));
endmodule

// File: rtl/lnb_sysreg_i2c.sv
module lnb_sysreg_i2c
  import lnb_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [1:0] addr_pin_i,
  input  logic       pwr_ok_i,
  input  logic       ovl_flag_i,
  input  logic       ot_flag_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data, rd_a, rd_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_fsm #(.PIN_W(2), .ADDR_BASE(5'b00010)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .addr_pin(addr_pin_i), .pwr_ok(pwr_ok_i),
    .rd_a(rd_a), .rd_b(rd_b), .sda_pull(sda_pull_o), .wr_en(wr_en),
    .wr_data(wr_data)
  );

  lnb_reg_bank u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_data(wr_data),
    .ovl_flag(ovl_flag_i), .ot_flag(ot_flag_i), .rd_a(rd_a), .rd_b(rd_b)
  );
endmodule

// File: tb/lnb_sysreg_i2c_bench.sv
module lnb_sysreg_i2c_bench;
  localparam int H = 20;
  localparam int NVEC = 7;
  // {addr7, data, expected ack, expected reg A, expected reg B}
  localparam logic [31:0] VEC [NVEC] = '{
    {7'h0A, 8'h7E, 1'b1, 8'h7E, 8'h00},
    {7'h0A, 8'h00, 1'b1, 8'h00, 8'h00},
    {7'h0A, 8'hFF, 1'b1, 8'h00, 8'h04},
    {7'h0B, 8'h7E, 1'b0, 8'h00, 8'h04},
    {7'h2A, 8'h55, 1'b0, 8'h00, 8'h04},
    {7'h0A, 8'h2B, 1'b1, 8'h2A, 8'h04},
    {7'h0A, 8'h80, 1'b1, 8'h2A, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n, scl, m_low, pg, ovl, ot;
  logic [1:0] pins;
  logic pull, sda;
  int n_chk = 0, n_fail = 0, early_pull = 0, r11_bad = 0;
  logic pull_seen = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;
  assign sda = ~(m_low | pull);

  lnb_sysreg_i2c u_lnb_sysreg_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_pull_o(pull),
    .addr_pin_i(pins), .pwr_ok_i(pg), .ovl_flag_i(ovl), .ot_flag_i(ot)
  );

  // R11 monitor: the pull enable may only move while SCL is low
  always @(negedge clk) begin
    if (rst_n === 1'b1 && pull !== pull_seen && scl === 1'b1) r11_bad++;
    pull_seen = pull;
  end

  task automatic hw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_low = 1'b0; hw(H/2); scl = 1'b1; hw(H); m_low = 1'b1; hw(H); scl = 1'b0; hw(H/2);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; hw(H/2); scl = 1'b1; hw(H); m_low = 1'b0; hw(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      hw(H/2); m_low = ~b[i]; hw(H/2); scl = 1'b1; hw(H/2);
      if (pull) early_pull++;
      hw(H/2); scl = 1'b0;
    end
    hw(H/2); m_low = 1'b0; hw(H/2); scl = 1'b1; hw(H/2);
    ack = ~sda; hw(H/2); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hw(H/2); m_low = 1'b0; hw(H/2); scl = 1'b1; hw(H/2);
      b[i] = sda; hw(H/2); scl = 1'b0;
    end
    hw(H/2); m_low = m_ack; hw(H/2); scl = 1'b1; hw(H); scl = 1'b0;
  endtask

  task automatic read_regs(output logic ack, output logic [7:0] a, output logic [7:0] b);
    bus_start; send_byte(8'h15, ack); recv_byte(1'b1, a); recv_byte(1'b0, b); bus_stop;
  endtask

  initial begin
    hw(190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic aa, ad, ad2, ad3;
    logic [7:0] ra, rb, rc;
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0; pg = 1'b1; ovl = 1'b0; ot = 1'b0;
    pins = 2'b10;
    hw(5); rst_n = 1'b1; hw(5);

    // R8 reset state
    chk("R8 pull after reset", int'(pull), 0);
    read_regs(aa, ra, rb);
    chk("R1 read address ack", int'(aa), 1);
    chk("R8 reg A reset", int'(ra), 8'h00);
    chk("R8 reg B reset", int'(rb), 8'h00);

    // table: R1 R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      v = VEC[i];
      bus_start;
      send_byte({v[31:25], 1'b0}, aa);
      send_byte(v[24:17], ad);
      bus_stop;
      chk("R1 R2 address ack", int'(aa), int'(v[16]));
      chk("R2 data ack", int'(ad), int'(v[16]));
      read_regs(aa, ra, rb);
      chk("R3 R4 reg A", int'(ra), int'(v[15:8]));
      chk("R4 reg B", int'(rb), int'(v[7:0]));
    end

    // R5 flags merged and not writable
    ovl = 1'b1; ot = 1'b1;
    read_regs(aa, ra, rb);
    chk("R5 reg A flag", int'(ra), 8'h2B);
    chk("R5 reg B flag", int'(rb), 8'h02);
    ovl = 1'b0; ot = 1'b0;
    bus_start; send_byte(8'h14, aa); send_byte(8'h01, ad); send_byte(8'h83, ad2); bus_stop;
    read_regs(aa, ra, rb);
    chk("R5 reg A flag unwritable", int'(ra), 8'h00);
    chk("R5 reg B flag unwritable", int'(rb), 8'h00);

    // R6 multi-byte write
    bus_start; send_byte(8'h14, aa); send_byte(8'h12, ad); send_byte(8'h84, ad2); bus_stop;
    chk("R6 first data ack", int'(ad), 1);
    chk("R6 second data ack", int'(ad2), 1);
    read_regs(aa, ra, rb);
    chk("R6 reg A", int'(ra), 8'h12);
    chk("R6 reg B", int'(rb), 8'h04);

    // R9 read order and release after NACK
    bus_start; send_byte(8'h15, aa);
    recv_byte(1'b1, ra); recv_byte(1'b1, rb); recv_byte(1'b0, rc);
    chk("R9 first byte A", int'(ra), 8'h12);
    chk("R9 second byte B", int'(rb), 8'h04);
    chk("R9 third byte A", int'(rc), 8'h12);
    recv_byte(1'b0, rc);
    bus_stop;
    chk("R9 released after NACK", int'(rc), 8'hFF);

    // R7 power-good gating on address
    pg = 1'b0;
    bus_start; send_byte(8'h14, aa); send_byte(8'h00, ad); bus_stop;
    pg = 1'b1;
    chk("R7 no address ack", int'(aa), 0);
    chk("R7 no data ack", int'(ad), 0);
    read_regs(aa, ra, rb);
    chk("R7 reg A kept", int'(ra), 8'h12);
    // R7 power-good gating on data
    bus_start; send_byte(8'h14, aa); pg = 1'b0; send_byte(8'h00, ad); bus_stop;
    pg = 1'b1;
    chk("R7 address ack with power", int'(aa), 1);
    chk("R7 data not acked", int'(ad), 0);
    read_regs(aa, ra, rb);
    chk("R7 reg A not written", int'(ra), 8'h12);

    // R10 repeated START switches to a read
    bus_start; send_byte(8'h14, aa); bus_start; send_byte(8'h15, ad); recv_byte(1'b0, ra); bus_stop;
    chk("R10 restart address ack", int'(ad), 1);
    chk("R10 restart read A", int'(ra), 8'h12);
    // R10 STOP abort: bytes without START are ignored
    bus_start; send_byte(8'h14, aa); bus_stop;
    send_byte(8'h00, ad3); bus_stop;
    chk("R10 byte after STOP ignored", int'(ad3), 0);
    read_regs(aa, ra, rb);
    chk("R10 reg A after abort", int'(ra), 8'h12);

    chk("R3 no pull during data bits", early_pull, 0);
    chk("R11 pull moved with SCL high", r11_bad, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule